// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block gathers every interrupt source of a USB device controller into one status word and drives a single interrupt line toward the CPU. Three of the status bits are sticky bus events: wake-up, end of host resume, and device-sent (upstream) resume. Software drops these only by writing ones to a separate clear register. The remaining bits are per-endpoint and per-DMA-channel flags. Each one is the live interrupt level of its source, masked by its enable bit, so it falls as soon as the engine that owns it clears its own status.

The wake-up detector runs on a free-running slow clock, so it keeps working while the main controller clock is gated off. It accepts only line activity that lasts a programmable number of slow-clock samples while the controller is suspended, and it ignores the device's own resume signalling. Once the flag is set it raises the interrupt line directly, without help from the main clock. A two-flop synchroniser then carries it into the status word.

Top module: `usb_irq_aggregator`

## Requirements
- R1: After reset the status word, the enable register and the interrupt line are all 0.
- R2: Status bit 1 (end of resume) is set by a one-cycle `eor_pulse`. It holds until a 1 is written to bit 1 of the clear register (address 2).
- R3: Status bit 2 (upstream resume) is set in each cycle in which `upres_active` is high. It holds until a 1 is written to bit 2 of the clear register.
- R4: Writing 0 to a clear-register bit leaves that status bit unchanged. The clear register reads as 0. The enable register (address 1) reads back the value written to it.
- R5: When a set event and a clear write of the same sticky bit fall in one cycle, the bit ends up set.
- R6: Endpoint status bit 3+i equals `ep_src[i]` ANDed with enable bit 3+i. It falls with its source.
- R7: DMA status bit 3+NUM_EP+j equals `dma_src[j]` ANDed with its enable bit. It falls with its source.
- R8: `irq` is high exactly when some status bit and its enable bit are both 1. An asserted bit whose enable is 0 does not raise `irq`.
- R9: Wake-up (status bit 0) is set only while `suspended` is high and `line_nonidle` has been high for FILT_LEN consecutive slow-clock samples. Shorter bursts, or activity while not suspended, leave it at 0.
- R10: Line activity while `upres_active` is high does not set wake-up.
- R11: Once wake-up is set and enable bit 0 is 1, `irq` rises even with the main clock stopped.
- R12: Wake-up becomes visible in status bit 0 through a two-flop synchroniser. A write of 1 to clear bit 0 drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main controller clock, may be gated |
| slow_clk | input | 1 | Free-running slow clock for the wake detector |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 status, 1 enable, 2 clear |
| reg_wdata | input | 3+NUM_EP+NUM_DMA | Write data |
| reg_rdata | output | 3+NUM_EP+NUM_DMA | Combinational read data |
| suspended | input | 1 | Controller is in the suspend state |
| line_nonidle | input | 1 | Asynchronous non-idle indication from the USB line |
| upres_active | input | 1 | Controller is sending resume to the host |
| eor_pulse | input | 1 | End of host resume detected (one cycle) |
| ep_src | input | NUM_EP | Endpoint interrupt levels |
| dma_src | input | NUM_DMA | DMA channel interrupt levels |
| irq | output | 1 | Shared interrupt line |

## Verification
On every cycle the assertions check the following. The sticky bits hold unless a matching 1 is written to the clear register, and a set event always leaves its bit at 1. Endpoint and DMA bits drop when their sources are idle. With no enables set, `irq` stays low. On the slow clock they check that every rise of the wake flag was preceded by a full filter window while suspended, with no upstream resume active, and that an enabled wake flag drives `irq`. Only the bench scenarios can show the rest: that a short burst never wakes the block, that `irq` rises while the main clock is really stopped, and that the clear handshake across the two domains finally drops status bit 0.

// File: rtl/uia_pkg.sv
package uia_pkg;
  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_ENABLE = 2'd1;
  localparam logic [1:0] ADDR_CLEAR  = 2'd2;

  localparam int BIT_WAKE = 0;
  localparam int BIT_EOR  = 1;
  localparam int BIT_UPR  = 2;
  localparam int BIT_EP0  = 3;

  // Next value of a sticky event bit; a set in the same cycle beats a clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Width of the status word for a given source count.
  function automatic int status_width(input int n_ep, input int n_dma);
    return BIT_EP0 + n_ep + n_dma;
  endfunction
endpackage

// File: rtl/uia_sticky_bits.sv
module uia_sticky_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  import uia_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= sticky_next(q_o[i], set_i[i], clr_i[i]);
    end
  end
endmodule

// File: rtl/uia_wake_det.sv
module uia_wake_det #(
  parameter int FILT_LEN = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic slow_clk,
  input  logic rst_n,
  input  logic line_nonidle,
  input  logic suspended,
  input  logic upres_active,
  input  logic clr_pulse,
  output logic wake_flag,
  output logic wake_main,
  output logic filt_ok,
  output logic susp_s,
  output logic upr_s
);
  import uia_pkg::*;
  localparam int CW = $clog2(FILT_LEN + 1);

  // ---------------- slow, always-on domain ----------------
  logic [SYNC_LEN-1:0] line_ff, susp_ff, upr_ff, clrreq_ff;
  logic                line_s, clrreq_s;
  logic [CW-1:0]       run_cnt;
  logic                wake_set;
  logic                clr_req_m;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      line_ff   <= '0;
      susp_ff   <= '0;
      upr_ff    <= '0;
      clrreq_ff <= '0;
    end else begin
      line_ff   <= {line_ff[SYNC_LEN-2:0], line_nonidle};
      susp_ff   <= {susp_ff[SYNC_LEN-2:0], suspended};
      upr_ff    <= {upr_ff[SYNC_LEN-2:0], upres_active};
      clrreq_ff <= {clrreq_ff[SYNC_LEN-2:0], clr_req_m};
    end
  end

  assign line_s   = line_ff[SYNC_LEN-1];
  assign susp_s   = susp_ff[SYNC_LEN-1];
  assign upr_s    = upr_ff[SYNC_LEN-1];
  assign clrreq_s = clrreq_ff[SYNC_LEN-1];

  // Consecutive-sample counter; saturates at FILT_LEN, restarts on any idle sample.
  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n)                        run_cnt <= '0;
    else if (!line_s)                  run_cnt <= '0;
    else if (run_cnt != CW'(FILT_LEN)) run_cnt <= run_cnt + 1'b1;
  end

  assign filt_ok  = (run_cnt == CW'(FILT_LEN));
  assign wake_set = filt_ok & susp_s & ~upr_s;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) wake_flag <= 1'b0;
    else        wake_flag <= sticky_next(wake_flag, wake_set, clrreq_s);
  end

  // ---------------- main (gateable) domain ----------------
  logic [SYNC_LEN-1:0] wake_ff, ack_ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_ff <= '0;
      ack_ff  <= '0;
    end else begin
      wake_ff <= {wake_ff[SYNC_LEN-2:0], wake_flag};
      ack_ff  <= {ack_ff[SYNC_LEN-2:0], clrreq_s};
    end
  end

  // Clear request is held as a level until the slow side echoes it back.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    clr_req_m <= 1'b0;
    else if (clr_pulse)            clr_req_m <= 1'b1;
    else if (ack_ff[SYNC_LEN-1])   clr_req_m <= 1'b0;
  end

  assign wake_main = wake_ff[SYNC_LEN-1];
endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator #(
  parameter int NUM_EP   = 4,
  parameter int NUM_DMA  = 2,
  parameter int FILT_LEN = 4,
  localparam int W = uia_pkg::status_width(NUM_EP, NUM_DMA)
) (
  input  logic               clk,
  input  logic               slow_clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [W-1:0]       reg_wdata,
  output logic [W-1:0]       reg_rdata,
  input  logic               suspended,
  input  logic               line_nonidle,
  input  logic               upres_active,
  input  logic               eor_pulse,
  input  logic [NUM_EP-1:0]  ep_src,
  input  logic [NUM_DMA-1:0] dma_src,
  output logic               irq
);
  import uia_pkg::*;
  localparam int BIT_DMA0 = BIT_EP0 + NUM_EP;

  logic [W-1:0]       en_q, clr_vec, status_w;
  logic               wr_en, wr_clr;
  logic               st_eor, st_upr, wake_m;
  logic               wake_flag_s, filt_ok, susp_s, upr_s;
  logic [NUM_EP-1:0]  ep_st;
  logic [NUM_DMA-1:0] dma_st;

  assign wr_en   = reg_wr && (reg_addr == ADDR_ENABLE);
  assign wr_clr  = reg_wr && (reg_addr == ADDR_CLEAR);
  assign clr_vec = wr_clr ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= reg_wdata;
  end

  uia_sticky_bits #(.N(2)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i ({upres_active, eor_pulse}),
    .clr_i ({clr_vec[BIT_UPR], clr_vec[BIT_EOR]}),
    .q_o   ({st_upr, st_eor})
  );

  uia_wake_det #(.FILT_LEN(FILT_LEN)) u_wake (
    .clk          (clk),
    .slow_clk     (slow_clk),
    .rst_n        (rst_n),
    .line_nonidle (line_nonidle),
    .suspended    (suspended),
    .upres_active (upres_active),
    .clr_pulse    (clr_vec[BIT_WAKE]),
    .wake_flag    (wake_flag_s),
    .wake_main    (wake_m),
    .filt_ok      (filt_ok),
    .susp_s       (susp_s),
    .upr_s        (upr_s)
  );

  assign ep_st  = ep_src  & en_q[BIT_EP0  +: NUM_EP];
  assign dma_st = dma_src & en_q[BIT_DMA0 +: NUM_DMA];

  assign status_w = {dma_st, ep_st, st_upr, st_eor, wake_m};

  // The wake term uses the slow-domain flag so the line works with clk gated.
  assign irq = (|(status_w[W-1:1] & en_q[W-1:1])) | (wake_flag_s & en_q[BIT_WAKE]);

  always_comb begin
    case (reg_addr)
      ADDR_STATUS: reg_rdata = status_w;
      ADDR_ENABLE: reg_rdata = en_q;
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uia_checker.sv
module uia_checker #(
  parameter int NUM_EP  = 4,
  parameter int NUM_DMA = 2,
  localparam int W = uia_pkg::status_width(NUM_EP, NUM_DMA)
) (
  input logic               clk,
  input logic               slow_clk,
  input logic               rst_n,
  input logic               clr_eor,
  input logic               clr_upr,
  input logic               eor_pulse,
  input logic               upres_active,
  input logic               st_eor,
  input logic               st_upr,
  input logic [NUM_EP-1:0]  ep_src,
  input logic [NUM_EP-1:0]  ep_st,
  input logic [NUM_DMA-1:0] dma_src,
  input logic [NUM_DMA-1:0] dma_st,
  input logic [W-1:0]       en_q,
  input logic               irq,
  input logic               wake_flag,
  input logic               filt_ok,
  input logic               susp_s,
  input logic               upr_s
);
  assert_eor_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_eor && !clr_eor) |=> st_eor);

  assert_upr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upres_active |=> st_upr);

  assert_upr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_upr && !clr_upr) |=> st_upr);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_pulse && clr_eor) |=> st_eor);

  assert_ep_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_src == '0) |-> (ep_st == '0));

  assert_dma_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_src == '0) |-> (dma_st == '0));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  assert_wake_filter_R9: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(filt_ok && susp_s));

  assert_wake_not_own_R10: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(!upr_s));

  assert_wake_irq_R11: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (wake_flag && en_q[0]) |-> irq);
endmodule

bind usb_irq_aggregator uia_checker #(.NUM_EP(NUM_EP), .NUM_DMA(NUM_DMA)) u_chk (
  .clk          (clk),
  .slow_clk     (slow_clk),
  .rst_n        (rst_n),
  .clr_eor      (clr_vec[1]),
  .clr_upr      (clr_vec[2]),
  .eor_pulse    (eor_pulse),
  .upres_active (upres_active),
  .st_eor       (st_eor),
  .st_upr       (st_upr),
  .ep_src       (ep_src),
  .ep_st        (ep_st),
  .dma_src      (dma_src),
  .dma_st       (dma_st),
  .en_q         (en_q),
  .irq          (irq),
  .wake_flag    (wake_flag_s),
  .filt_ok      (filt_ok),
  .susp_s       (susp_s),
  .upr_s        (upr_s)
);

// File: tb/usb_irq_aggregator_bench.sv
module usb_irq_aggregator_bench;
  localparam int NEP = 4;
  localparam int NDMA = 2;
  localparam int W = 3 + NEP + NDMA;

  logic clk = 1'b0, slow_clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0, reg_rdata;
  logic suspended = 1'b0, line_nonidle = 1'b0, upres_active = 1'b0, eor_pulse = 1'b0;
  logic [NEP-1:0] ep_src = '0;
  logic [NDMA-1:0] dma_src = '0;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always begin #10; if (clk_run) clk = ~clk; end
  always #50 slow_clk = ~slow_clk;

  usb_irq_aggregator #(.NUM_EP(NEP), .NUM_DMA(NDMA), .FILT_LEN(4)) u_usb_irq_aggregator (
    .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .suspended(suspended),
    .line_nonidle(line_nonidle), .upres_active(upres_active), .eor_pulse(eor_pulse),
    .ep_src(ep_src), .dma_src(dma_src), .irq(irq)
  );

  typedef struct packed {
    logic [3:0] ep;
    logic [1:0] dma;
    logic       eor;
    logic       upr;
    logic       wr;
    logic [1:0] addr;
    logic [8:0] wdata;
    logic [8:0] exp_st;
    logic       exp_irq;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{4'b0000, 2'b00, 1'b0, 1'b0, 1'b1, 2'd1, 9'h1FF, 9'h000, 1'b0}, // R8 enable all
    '{4'b0000, 2'b00, 1'b1, 1'b0, 1'b0, 2'd0, 9'h000, 9'h002, 1'b1}, // R2 eor set
    '{4'b0101, 2'b00, 1'b0, 1'b0, 1'b0, 2'd0, 9'h000, 9'h02A, 1'b1}, // R6 endpoints
    '{4'b0101, 2'b00, 1'b0, 1'b0, 1'b1, 2'd2, 9'h002, 9'h028, 1'b1}, // R2 clear eor
    '{4'b0000, 2'b10, 1'b0, 1'b1, 1'b0, 2'd0, 9'h000, 9'h104, 1'b1}, // R3 R7
    '{4'b0000, 2'b10, 1'b0, 1'b0, 1'b1, 2'd2, 9'h000, 9'h104, 1'b1}, // R4 zero clear
    '{4'b0000, 2'b10, 1'b0, 1'b0, 1'b1, 2'd1, 9'h000, 9'h004, 1'b0}, // R8 all masked
    '{4'b0000, 2'b10, 1'b1, 1'b0, 1'b1, 2'd2, 9'h002, 9'h006, 1'b0}, // R5 set wins
    '{4'b0000, 2'b10, 1'b0, 1'b0, 1'b1, 2'd1, 9'h006, 9'h006, 1'b1}, // R8 partial enable
    '{4'b0000, 2'b00, 1'b0, 1'b0, 1'b1, 2'd2, 9'h006, 9'h000, 1'b0}  // R3 clear both
  };

  function automatic string vec_req(input int i);
    case (i)
      1, 3:    return "R2";
      2:       return "R6";
      4, 9:    return "R3";
      5:       return "R4";
      7:       return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic idle_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200_000 * 20);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd;
    #55 rst_n = 1'b1;

    // R1 reset state
    read_reg(2'd0, rd); check("R1 status", rd, '0);
    check("R1 irq", W'(irq), '0);
    read_reg(2'd1, rd); check("R1 enable", rd, '0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ep_src = VEC[i].ep; dma_src = VEC[i].dma; eor_pulse = VEC[i].eor;
      upres_active = VEC[i].upr; reg_wr = VEC[i].wr; reg_addr = VEC[i].addr;
      reg_wdata = VEC[i].wdata;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0; eor_pulse = 1'b0;
      #1;
      check(vec_req(i), reg_rdata, VEC[i].exp_st);
      check(vec_req(i), W'(irq), W'(VEC[i].exp_irq));
    end

    // R4 readback of enable and clear registers
    read_reg(2'd1, rd); check("R4 enable readback", rd, 9'h006);
    read_reg(2'd2, rd); check("R4 clear reads zero", rd, '0);

    // Wake tests: only wake enabled
    write_reg(2'd1, 9'h001);

    // R9 short burst while suspended is ignored
    suspended = 1'b1;
    #500;
    line_nonidle = 1'b1; #150; line_nonidle = 1'b0;
    #2000;
    read_reg(2'd0, rd); check("R9 short burst", rd, '0);
    check("R9 short burst irq", W'(irq), '0);

    // R10 activity during own upstream resume is ignored
    upres_active = 1'b1; #500;
    line_nonidle = 1'b1; #1000; line_nonidle = 1'b0; #500;
    upres_active = 1'b0; #500;
    read_reg(2'd0, rd); check("R10 no wake during own resume", rd & 9'h001, '0);
    check("R10 irq", W'(irq), '0);
    write_reg(2'd2, 9'h004);
    read_reg(2'd0, rd); check("R3 upr cleared", rd, '0);

    // R11 wake raises irq with main clock stopped
    @(negedge clk); clk_run = 1'b0;
    line_nonidle = 1'b1; #1000;
    check("R11 irq with clock stopped", W'(irq), 9'h001);
    line_nonidle = 1'b0; #200;
    clk_run = 1'b1;

    // R12 synchronised visibility, then clear handshake
    idle_clk(4);
    read_reg(2'd0, rd); check("R12 wake visible", rd, 9'h001);
    write_reg(2'd2, 9'h001);
    idle_clk(60);
    read_reg(2'd0, rd); check("R12 wake cleared", rd, '0);
    check("R12 irq low", W'(irq), '0);

    // R9 long activity while not suspended is ignored
    suspended = 1'b0; #500;
    line_nonidle = 1'b1; #1000; line_nonidle = 1'b0; #500;
    read_reg(2'd0, rd); check("R9 not suspended", rd, '0);
    check("R9 not suspended irq", W'(irq), '0);

    // R6 R7 follow sources with enables; falling source drops bit
    write_reg(2'd1, 9'h1F8);
    @(negedge clk); ep_src = 4'b1000; dma_src = 2'b01;
    #1 check("R6 R7 set", reg_rdata, 9'h0C0);
    @(negedge clk); ep_src = 4'b0000;
    #1 check("R6 drop", reg_rdata, 9'h080);
    @(negedge clk); dma_src = 2'b00;
    #1 check("R7 drop", reg_rdata, 9'h000);
    check("R8 idle irq", W'(irq), '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule